// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the byte-wide register front end of a two-channel serial controller. A host reaches it through a two-bit address, separate read and write strobes, and 8-bit data. The address picks one of the two channels and either that channel's control port or its data port. Control accesses are indirect. A write to register 0 loads a register pointer, and the next control access goes to the register that the pointer names. After that access the pointer falls back to 0. Register 0 writes also carry command codes that clear interrupts.

The block keeps the configuration bits that affect behaviour: interrupt enables, receive mode, receive enable, transmit enable, break-interrupt enable and vector encoding. It also keeps per-channel receive and break status, per-source pending and in-service flags, and one shared interrupt vector. It drives a single interrupt request. Each channel hands received bytes in and transmitted bytes out through a plain valid/ready style port. Bit timing, baud generation and line coding are handled elsewhere.

Top module: `dual_serial_regs`

## Requirements
- R1: Address bit 2 selects the channel (0 = channel B, 1 = channel A). Address bit 1 selects the control port (0) or the data port (1).
- R2: A control write while the pointer is 0 loads pointer bits 2:0 from data bits 2:0. Command field bits 5:3 equal to 001 also set pointer bit 3. A control write to a non-zero pointer returns the pointer to 0. Every control read returns the register at the pointer and returns the pointer to 0.
- R3: After reset the following hold: read register 0 (status) reads 0x44; read register 1 reads 0x07; the vector (read register 2) is 0x00; the pending register (read register 3) is 0x00; irq_o is low; rx_ready_o is low.
- R4: Write register 9 bits 7:6 request a reset: 01 resets channel B, 10 resets channel A, 11 resets both. A channel reset restores that channel's reset state. Resetting channel B also sets the vector to 0x00. When the writing channel is not itself reset, its pointer keeps the value 9. A write to register 9 with bits 7:6 equal to 00 stores bit 4 as the status-high vector selection.
- R5: Command field 101 (write 0x28) clears the channel's tx pending and tx in-service flags. Command field 111 (write 0x38) clears the in-service source, checking rx before tx; when neither source is in service it does nothing.
- R6: A data write makes tx pending on that channel. The byte appears on tx_data_o with tx_valid_o for one cycle after the write, but only if write register 5 bit 3 is set.
- R7: rx_ready_o is high only when write register 3 bit 0 is set and no received byte is waiting. An accepted byte sets status bit 0 and makes rx pending. A data read returns the byte, clears status bit 0 and clears rx pending and rx in-service.
- R8: A channel requests an interrupt when write register 1 bit 0 is set and at least one of these holds: bit 1 is set with tx pending; bits 4:3 are 01 or 10 with rx pending; write register 15 bit 7 is set with break status set. irq_o is the OR of the two channels.
- R9: The vector values are listed as status-high / status-low: idle 0x60/0x06, rx A 0x30/0x0C, rx B 0x20/0x04, tx A 0x10/0x08, tx B 0x00/0x00. Each code uses the status-high bit of the channel that caused the update.
- R10: Read register 3, read through channel A, holds pending bits at these positions: ext B bit 0, tx B bit 1, rx B bit 2, ext A bit 3, tx A bit 4, rx A bit 5. The ext bit is break status AND write register 15 bit 7. Read through channel B it returns 0x00.
- R11: A source that becomes pending while the other source of the same channel is in service sets its pending bit but leaves the vector unchanged. Clearing a source with a clear command or a data read sets the vector to its idle code. If the other source of that channel is still pending, it then takes service and the vector.
- R12: Events that land in the same cycle are applied in this order: clears first, then tx sets, then rx sets, with channel B before channel A within each group.
- R13: A pulse on brk_i sets status bit 7 of that channel. Only a channel reset clears it. Write register 15 bit 7 resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Address bits 2:1 (channel, control/data) |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed port |
| rx_valid_i | input | 2 | Received byte offered, bit 0 = B, bit 1 = A |
| rx_data_i | input | 16 | Received bytes, B in 7:0, A in 15:8 |
| rx_ready_o | output | 2 | Channel can accept a byte |
| brk_i | input | 2 | Break detected pulse per channel |
| tx_valid_o | output | 2 | Transmit byte strobe per channel |
| tx_data_o | output | 16 | Transmit bytes, B in 7:0, A in 15:8 |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a tie between the two sources of one channel, where the vector and the pending register disagree about which source is active. Examples are an rx arriving while tx is in service, or two rx bytes landing on both channels in the same cycle. The stimulus builds each of these states on purpose. It injects rx bytes during the same cycle as a data write, offers bytes on both channels at once, and alternates clear-in-service and data-read commands. After every step it reads the vector and the pending register through the pointer and compares them with an event-ordered model, under both vector encodings. A reset of channel B issued through channel A shows the pointer left at 9, because a control read then returns register 9 instead of status.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int DATA_W = 8;
  localparam int NCH    = 2;
  localparam int PTR_W  = 4;
  localparam int CH_B   = 0;
  localparam int CH_A   = 1;

  localparam logic [2:0] CMD_HI      = 3'b001;
  localparam logic [2:0] CMD_CLR_TX  = 3'b101;
  localparam logic [2:0] CMD_CLR_IUS = 3'b111;

  localparam logic [PTR_W-1:0] P_IEN  = 4'd1;
  localparam logic [PTR_W-1:0] P_RXC  = 4'd3;
  localparam logic [PTR_W-1:0] P_TXC  = 4'd5;
  localparam logic [PTR_W-1:0] P_RST  = 4'd9;
  localparam logic [PTR_W-1:0] P_EXT  = 4'd15;

  localparam logic [DATA_W-1:0] SPEC_RST = 8'h07;

  typedef enum logic [1:0] {VK_IDLE, VK_RX, VK_TX} vkind_e;

  function automatic logic [DATA_W-1:0] vcode(vkind_e k, logic is_a, logic hi);
    logic [DATA_W-1:0] v;
    unique case (k)
      VK_RX:   v = is_a ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
      VK_TX:   v = is_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
      default: v = hi ? 8'h60 : 8'h06;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/ser_chan.sv
module ser_chan
  import ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              ctrl_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              chan_rst_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              brk_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [1:0]        rst_req_o,
  output logic              clr_tx_o,
  output logic              clr_ius_o,
  output logic              data_rd_o,
  output logic              data_wr_o,
  output logic              rx_acc_o,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic [DATA_W-1:0] status_o,
  output logic              int_en_o,
  output logic              tx_ie_o,
  output logic [1:0]        rx_mode_o,
  output logic              brk_ie_o,
  output logic              hi_o,
  output logic              brk_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic              rx_en_q, tx_en_q, rxav_q;
  logic [DATA_W-1:0] rx_byte_q;
  logic              ctrl_wr, ctrl_rd, wr_rst;
  logic [2:0]        cmd;

  assign ctrl_wr   = sel_i & ctrl_i & wr_i;
  assign ctrl_rd   = sel_i & ctrl_i & rd_i;
  assign data_wr_o = sel_i & ~ctrl_i & wr_i;
  assign data_rd_o = sel_i & ~ctrl_i & rd_i;
  assign cmd       = wdata_i[5:3];
  assign wr_rst    = ctrl_wr && (ptr_q == P_RST) && (wdata_i[7:6] != 2'b00);
  assign rst_req_o = wr_rst ? wdata_i[7:6] : 2'b00;
  assign clr_tx_o  = ctrl_wr && (ptr_q == '0) && (cmd == CMD_CLR_TX);
  assign clr_ius_o = ctrl_wr && (ptr_q == '0) && (cmd == CMD_CLR_IUS);
  assign rx_ready_o = rx_en_q & ~rxav_q;
  assign rx_acc_o   = rx_valid_i & rx_ready_o & ~chan_rst_i;
  assign ptr_o      = ptr_q;
  assign rx_byte_o  = rx_byte_q;
  assign status_o   = {brk_o, 1'b1, 3'b000, 1'b1, 1'b0, rxav_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0; rx_en_q <= 1'b0; tx_en_q <= 1'b0; rxav_q <= 1'b0;
      rx_byte_q <= '0; int_en_o <= 1'b0; tx_ie_o <= 1'b0; rx_mode_o <= 2'b00;
      brk_ie_o <= 1'b1; hi_o <= 1'b0; brk_o <= 1'b0;
      tx_valid_o <= 1'b0; tx_data_o <= '0;
    end else if (chan_rst_i) begin
      ptr_q <= '0; rx_en_q <= 1'b0; tx_en_q <= 1'b0; rxav_q <= 1'b0;
      rx_byte_q <= '0; int_en_o <= 1'b0; tx_ie_o <= 1'b0; rx_mode_o <= 2'b00;
      brk_ie_o <= 1'b1; hi_o <= 1'b0; brk_o <= 1'b0;
      tx_valid_o <= 1'b0; tx_data_o <= '0;
    end else begin
      if (ctrl_rd) ptr_q <= '0;
      else if (ctrl_wr) begin
        if (ptr_q == '0)  ptr_q <= {cmd == CMD_HI, wdata_i[2:0]};
        else if (!wr_rst) ptr_q <= '0;
        unique case (ptr_q)
          P_IEN: begin int_en_o <= wdata_i[0]; tx_ie_o <= wdata_i[1]; rx_mode_o <= wdata_i[4:3]; end
          P_RXC: rx_en_q <= wdata_i[0];
          P_TXC: tx_en_q <= wdata_i[3];
          P_RST: if (wdata_i[7:6] == 2'b00) hi_o <= wdata_i[4];
          P_EXT: brk_ie_o <= wdata_i[7];
          default: ;
        endcase
      end
      if (rx_acc_o) begin rxav_q <= 1'b1; rx_byte_q <= rx_data_i; end
      else if (data_rd_o) rxav_q <= 1'b0;
      if (brk_i) brk_o <= 1'b1;
      tx_valid_o <= data_wr_o & tx_en_q;
      if (data_wr_o) tx_data_o <= wdata_i;
    end
  end

  AST_PTR_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl_rd || (ctrl_wr && ptr_q != '0 && !wr_rst)) && !chan_rst_i) |=> (ptr_q == '0)); // R2
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxav_q && !data_rd_o && !chan_rst_i) |=> (rxav_q && $stable(rx_byte_q))); // R7
  AST_TX_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_o && !tx_en_q) |=> !tx_valid_o); // R6
endmodule

// File: rtl/ser_irq.sv
module ser_irq
  import ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    chan_rst_i,
  input  logic [NCH-1:0]    clr_tx_i,
  input  logic [NCH-1:0]    clr_ius_i,
  input  logic [NCH-1:0]    clr_rx_i,
  input  logic [NCH-1:0]    set_tx_i,
  input  logic [NCH-1:0]    set_rx_i,
  input  logic [NCH-1:0]    hi_i,
  input  logic [NCH-1:0]    int_en_i,
  input  logic [NCH-1:0]    tx_ie_i,
  input  logic [2*NCH-1:0]  rx_mode_i,
  input  logic [NCH-1:0]    brk_ie_i,
  input  logic [NCH-1:0]    brk_i,
  output logic [DATA_W-1:0] vec_o,
  output logic [DATA_W-1:0] pend_o,
  output logic              irq_o
);
  logic [NCH-1:0] rxp_q, txp_q, rxs_q, txs_q;
  logic [NCH-1:0] rxp_n, txp_n, rxs_n, txs_n, req, ext;
  logic [DATA_W-1:0] vec_q, vec_n;

  always_comb begin
    logic do_crx, do_ctx;
    do_crx = 1'b0; do_ctx = 1'b0;
    rxp_n = rxp_q; txp_n = txp_q; rxs_n = rxs_q; txs_n = txs_q; vec_n = vec_q;
    for (int c = 0; c < NCH; c++)
      if (chan_rst_i[c]) begin
        rxp_n[c] = 1'b0; txp_n[c] = 1'b0; rxs_n[c] = 1'b0; txs_n[c] = 1'b0;
        if (c == CH_B) vec_n = '0;
      end
    for (int c = 0; c < NCH; c++) begin
      do_crx = clr_rx_i[c] | (clr_ius_i[c] & rxs_n[c]);
      do_ctx = clr_tx_i[c] | (clr_ius_i[c] & ~rxs_n[c] & txs_n[c]);
      if (do_crx) begin
        rxp_n[c] = 1'b0; rxs_n[c] = 1'b0; vec_n = vcode(VK_IDLE, c == CH_A, hi_i[c]);
        if (txp_n[c]) begin txs_n[c] = 1'b1; vec_n = vcode(VK_TX, c == CH_A, hi_i[c]); end
      end
      if (do_ctx) begin
        txp_n[c] = 1'b0; txs_n[c] = 1'b0; vec_n = vcode(VK_IDLE, c == CH_A, hi_i[c]);
        if (rxp_n[c]) begin rxs_n[c] = 1'b1; vec_n = vcode(VK_RX, c == CH_A, hi_i[c]); end
      end
    end
    for (int c = 0; c < NCH; c++)
      if (set_tx_i[c]) begin
        txp_n[c] = 1'b1;
        if (!rxs_n[c]) begin txs_n[c] = 1'b1; vec_n = vcode(VK_TX, c == CH_A, hi_i[c]); end
      end
    for (int c = 0; c < NCH; c++)
      if (set_rx_i[c]) begin
        rxp_n[c] = 1'b1;
        if (!txs_n[c]) begin rxs_n[c] = 1'b1; vec_n = vcode(VK_RX, c == CH_A, hi_i[c]); end
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxp_q <= '0; txp_q <= '0; rxs_q <= '0; txs_q <= '0; vec_q <= '0;
    end else begin
      rxp_q <= rxp_n; txp_q <= txp_n; rxs_q <= rxs_n; txs_q <= txs_n; vec_q <= vec_n;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_req
    logic rx_mode_ok;
    assign rx_mode_ok = (rx_mode_i[2*g+:2] == 2'b01) || (rx_mode_i[2*g+:2] == 2'b10);
    assign ext[g] = brk_i[g] & brk_ie_i[g];
    assign req[g] = int_en_i[g] & ((tx_ie_i[g] & txp_q[g]) | (rx_mode_ok & rxp_q[g]) | ext[g]);
  end

  assign irq_o  = |req;
  assign vec_o  = vec_q;
  assign pend_o = {2'b00, rxp_q[CH_A], txp_q[CH_A], ext[CH_A], rxp_q[CH_B], txp_q[CH_B], ext[CH_B]};

  AST_SVC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxs_q & txs_q) == '0); // R11
  AST_SVC_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rxs_q & ~rxp_q) | (txs_q & ~txp_q)) == '0); // R11
  AST_VEC_B_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_i[CH_B] |=> (vec_q == '0)); // R4
endmodule

// File: rtl/dual_serial_regs.sv
module dual_serial_regs
  import ser_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:1]            addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NCH-1:0]        rx_valid_i,
  input  logic [NCH*DATA_W-1:0] rx_data_i,
  output logic [NCH-1:0]        rx_ready_o,
  input  logic [NCH-1:0]        brk_i,
  output logic [NCH-1:0]        tx_valid_o,
  output logic [NCH*DATA_W-1:0] tx_data_o,
  output logic                  irq_o
);
  logic [PTR_W-1:0]  ptr    [NCH];
  logic [DATA_W-1:0] rxb    [NCH];
  logic [DATA_W-1:0] status [NCH];
  logic [1:0]        rst_req [NCH];
  logic [NCH-1:0] chan_rst, clr_tx, clr_ius, data_rd, data_wr, rx_acc;
  logic [NCH-1:0] int_en, tx_ie, brk_ie, hi, brk;
  logic [2*NCH-1:0] rx_mode;
  logic [DATA_W-1:0] vec, pend;

  assign chan_rst = rst_req[CH_B] | rst_req[CH_A];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ser_chan u_chan (
      .clk_i, .rst_ni,
      .sel_i      (addr_i[2] == g[0]),
      .ctrl_i     (~addr_i[1]),
      .wr_i, .rd_i, .wdata_i,
      .chan_rst_i (chan_rst[g]),
      .rx_valid_i (rx_valid_i[g]),
      .rx_data_i  (rx_data_i[g*DATA_W+:DATA_W]),
      .brk_i      (brk_i[g]),
      .ptr_o      (ptr[g]),
      .rst_req_o  (rst_req[g]),
      .clr_tx_o   (clr_tx[g]),
      .clr_ius_o  (clr_ius[g]),
      .data_rd_o  (data_rd[g]),
      .data_wr_o  (data_wr[g]),
      .rx_acc_o   (rx_acc[g]),
      .rx_ready_o (rx_ready_o[g]),
      .tx_valid_o (tx_valid_o[g]),
      .tx_data_o  (tx_data_o[g*DATA_W+:DATA_W]),
      .rx_byte_o  (rxb[g]),
      .status_o   (status[g]),
      .int_en_o   (int_en[g]),
      .tx_ie_o    (tx_ie[g]),
      .rx_mode_o  (rx_mode[2*g+:2]),
      .brk_ie_o   (brk_ie[g]),
      .hi_o       (hi[g]),
      .brk_o      (brk[g])
    );
  end

  ser_irq u_irq (
    .clk_i, .rst_ni,
    .chan_rst_i (chan_rst),
    .clr_tx_i   (clr_tx),
    .clr_ius_i  (clr_ius),
    .clr_rx_i   (data_rd),
    .set_tx_i   (data_wr),
    .set_rx_i   (rx_acc),
    .hi_i       (hi),
    .int_en_i   (int_en),
    .tx_ie_i    (tx_ie),
    .rx_mode_i  (rx_mode),
    .brk_ie_i   (brk_ie),
    .brk_i      (brk),
    .vec_o      (vec),
    .pend_o     (pend),
    .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i[1]) rdata_o = rxb[addr_i[2]];
    else
      unique case (ptr[addr_i[2]])
        4'd0:    rdata_o = status[addr_i[2]];
        4'd1:    rdata_o = SPEC_RST;
        4'd2:    rdata_o = vec;
        4'd3:    rdata_o = addr_i[2] ? pend : '0;
        default: rdata_o = '0;
      endcase
  end
endmodule

// File: tb/sim_dual_serial_regs.sv
`timescale 1ns/1ps
module sim_dual_serial_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:1] addr = '0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] rxv = '0, rx_ready, brk = '0, txv;
  logic [15:0] rxd = '0, txd;
  logic irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_serial_regs u0 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rxv), .rx_data_i(rxd), .rx_ready_o(rx_ready),
    .brk_i(brk), .tx_valid_o(txv), .tx_data_o(txd), .irq_o(irq));

  // model
  bit mrxp[2], mtxp[2], mrxs[2], mtxs[2], mhi[2], mbrk[2], mbrkie[2], mrxav[2], mrxen[2], mtxen[2];
  logic [7:0] mwr1[2], mbyte[2], mvec;

  function automatic logic [7:0] code(int k, int c, bit h);
    if (k == 1) return c ? (h ? 8'h30 : 8'h0C) : (h ? 8'h20 : 8'h04);
    if (k == 2) return c ? (h ? 8'h10 : 8'h08) : 8'h00;
    return h ? 8'h60 : 8'h06;
  endfunction
  function automatic void m_set_rx(int c);
    mrxp[c] = 1; if (!mtxs[c]) begin mrxs[c] = 1; mvec = code(1, c, mhi[c]); end
  endfunction
  function automatic void m_set_tx(int c);
    mtxp[c] = 1; if (!mrxs[c]) begin mtxs[c] = 1; mvec = code(2, c, mhi[c]); end
  endfunction
  function automatic void m_clr_rx(int c);
    mrxp[c] = 0; mrxs[c] = 0; mvec = code(0, c, mhi[c]); if (mtxp[c]) m_set_tx(c);
  endfunction
  function automatic void m_clr_tx(int c);
    mtxp[c] = 0; mtxs[c] = 0; mvec = code(0, c, mhi[c]); if (mrxp[c]) m_set_rx(c);
  endfunction
  function automatic void m_reset(int c);
    mrxp[c] = 0; mtxp[c] = 0; mrxs[c] = 0; mtxs[c] = 0; mhi[c] = 0; mbrk[c] = 0; mbrkie[c] = 1;
    mrxav[c] = 0; mrxen[c] = 0; mtxen[c] = 0; mwr1[c] = 0; mbyte[c] = 0;
    if (c == 0) mvec = 0;
  endfunction
  function automatic bit m_irq();
    bit r = 0;
    for (int c = 0; c < 2; c++)
      r |= mwr1[c][0] & ((mwr1[c][1] & mtxp[c]) | ((mwr1[c][4:3] == 2'b01 || mwr1[c][4:3] == 2'b10) & mrxp[c])
                         | (mbrkie[c] & mbrk[c]));
    return r;
  endfunction
  function automatic logic [7:0] m_pend();
    return {2'b00, mrxp[1], mtxp[1], mbrk[1] & mbrkie[1], mrxp[0], mtxp[0], mbrk[0] & mbrkie[0]};
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    nchk++;
    if (got !== exp) begin nfail++; $display("FAIL %s got %0h exp %0h", tag, got, exp); end
  endtask

  function automatic logic [2:0] ctl(int c); return c ? 3'd4 : 3'd0; endfunction
  function automatic logic [2:0] dat(int c); return c ? 3'd6 : 3'd2; endfunction

  task automatic wr_x(input logic [2:0] a, input logic [7:0] d, input logic [1:0] m, input logic [15:0] b);
    @(negedge clk); addr = a[2:1]; wdata = d; wr = 1; rxv = m; rxd = b;
    @(negedge clk); wr = 0; rxv = '0;
  endtask
  task automatic wrr(input logic [2:0] a, input logic [7:0] d); wr_x(a, d, 2'b00, 16'h0); endtask
  task automatic rdr(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a[2:1]; rd = 1; #1 v = rdata;
    @(negedge clk); rd = 0;
  endtask

  function automatic void m_rx(logic [1:0] m, logic [15:0] b);
    for (int c = 0; c < 2; c++)
      if (m[c] && mrxen[c] && !mrxav[c]) begin mrxav[c] = 1; mbyte[c] = b[c*8+:8]; m_set_rx(c); end
  endfunction
  task automatic rx(input logic [1:0] m, input logic [15:0] b);
    @(negedge clk); rxv = m; rxd = b; @(negedge clk); rxv = '0; m_rx(m, b);
  endtask
  task automatic drd(int c, string tag);
    logic [7:0] v; rdr(dat(c), v); chk(tag, v, mbyte[c]); mrxav[c] = 0; m_clr_rx(c);
  endtask
  task automatic dwr(int c, logic [7:0] d, string tag);
    wrr(dat(c), d); m_set_tx(c);
    chk(tag, txv[c], mtxen[c]);
    if (mtxen[c]) chk(tag, txd[c*8+:8], d);
  endtask
  task automatic cmd(int c, logic [7:0] d);
    wrr(ctl(c), d);
    if (d == 8'h28) m_clr_tx(c);
    else if (d == 8'h38) begin if (mrxs[c]) m_clr_rx(c); else if (mtxs[c]) m_clr_tx(c); end
  endtask
  task automatic check_int(string tag);
    logic [7:0] v;
    wrr(ctl(0), 8'h02); rdr(ctl(0), v); chk({tag, " R9 vec"}, v, mvec);
    wrr(ctl(1), 8'h03); rdr(ctl(1), v); chk({tag, " R10 pend"}, v, m_pend());
    chk({tag, " R8 irq"}, irq, m_irq());
  endtask
  task automatic setup(bit h);
    for (int c = 0; c < 2; c++) begin
      wrr(ctl(c), 8'h01); wrr(ctl(c), 8'h13);
      wrr(ctl(c), 8'h03); wrr(ctl(c), 8'h01);
      wrr(ctl(c), 8'h05); wrr(ctl(c), 8'h08);
      wrr(ctl(c), 8'h09); wrr(ctl(c), h ? 8'h10 : 8'h00);
      mwr1[c] = 8'h13; mrxen[c] = 1; mtxen[c] = 1; mhi[c] = h;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++; $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail); $finish;
    end
  end

  initial begin
    logic [7:0] v;
    m_reset(0); m_reset(1); mvec = 0;
    repeat (3) @(posedge clk); @(negedge clk); rst_n = 1;
    // R3 reset state
    rdr(ctl(0), v); chk("R3 rr0 B", v, 8'h44);
    rdr(ctl(1), v); chk("R3 rr0 A", v, 8'h44);
    wrr(ctl(0), 8'h01); rdr(ctl(0), v); chk("R3 rr1", v, 8'h07);
    chk("R3 rx_ready", rx_ready, 2'b00);
    check_int("R3 reset");
    // R6 tx gating while disabled
    dwr(0, 8'h33, "R6 tx disabled");
    check_int("R6 txB pend");
    cmd(0, 8'h28); check_int("R5 clr tx");
    for (int h = 0; h < 2; h++) begin
      wrr(ctl(0), 8'h09); wrr(ctl(0), 8'hC0); m_reset(0); m_reset(1);
      check_int("R4 reset both");
      setup(h[0]);
      for (int c = 0; c < 2; c++) begin
        logic [15:0] b = {8'hA0 + 8'(h*16 + c), 8'h50 + 8'(h*16 + c)};
        rx(2'(1 << c), b); check_int("R7 rx");
        rdr(ctl(c), v); chk("R7 rxav", v, 8'h45);
        drd(c, "R7 data"); check_int("R7 after read");
        dwr(c, 8'h3C ^ 8'(c), "R6 tx"); check_int("R6 tx int");
        cmd(c, 8'h28); check_int("R5 clr tx");
        rx(2'(1 << c), b); dwr(c, 8'h11, "R6 tx2"); check_int("R11 rx svc tx pend");
        cmd(c, 8'h38); check_int("R11 ius rx reraise tx");
        cmd(c, 8'h38); check_int("R5 ius tx");
        cmd(c, 8'h38); check_int("R5 ius none");
        drd(c, "R7 late read"); check_int("R7 late");
        dwr(c, 8'h22, "R6 tx3"); rx(2'(1 << c), b); check_int("R11 tx svc rx pend");
        cmd(c, 8'h28); check_int("R11 clr tx reraise rx");
        drd(c, "R7 read"); check_int("R7 idle");
      end
      rx(2'b11, 16'hC3_3C); check_int("R12 rx both");
      drd(1, "R1 data A"); check_int("R12 clr A");
      drd(0, "R1 data B"); check_int("R12 clr B");
      rx(2'b01, 16'h0077); dwr(1, 8'h44, "R6 txA"); check_int("R11 cross");
      cmd(1, 8'h38); check_int("R5 ius A");
      drd(0, "R1 data B2"); check_int("R5 drained");
      wr_x(dat(0), 8'h5A, 2'b11, 16'h9988); m_set_tx(0); m_rx(2'b11, 16'h9988);
      check_int("R12 tx+rx same cycle");
      cmd(0, 8'h28); drd(1, "R12 A"); drd(0, "R12 B"); check_int("R12 end");
    end
    // R7 second byte ignored
    rx(2'b01, 16'h0011); chk("R7 ready low", rx_ready[0], 1'b0);
    rx(2'b01, 16'h0022); drd(0, "R7 first byte kept"); check_int("R7 kept");
    // R2 pointer
    wrr(ctl(0), 8'h0B); rdr(ctl(0), v); chk("R2 ptr 11", v, 8'h00);
    rdr(ctl(0), v); chk("R2 ptr back", v, 8'h44);
    wrr(ctl(0), 8'h01); wrr(ctl(0), 8'h13); rdr(ctl(0), v); chk("R2 ptr after wr", v, 8'h44);
    wrr(ctl(0), 8'h02); rdr(ctl(0), v); rdr(ctl(0), v); chk("R2 read resets ptr", v, 8'h44);
    wrr(ctl(0), 8'h03); rdr(ctl(0), v); chk("R10 rr3 on B", v, 8'h00);
    // R4 reset A through A leaves B
    rx(2'b01, 16'h0066);
    wrr(ctl(1), 8'h09); wrr(ctl(1), 8'h80); m_reset(1);
    rdr(ctl(1), v); chk("R4 self reset ptr", v, 8'h44);
    check_int("R4 A reset keeps B");
    // R4 reset B through A: pointer stays 9
    wrr(ctl(1), 8'h09); wrr(ctl(1), 8'h40); m_reset(0);
    rdr(ctl(1), v); chk("R4 ptr kept 9", v, 8'h00);
    rdr(ctl(1), v); chk("R4 ptr then 0", v, 8'h44);
    check_int("R4 B reset vec");
    // R13 break
    wrr(ctl(0), 8'h01); wrr(ctl(0), 8'h01); mwr1[0] = 8'h01;
    @(negedge clk); brk = 2'b01; @(negedge clk); brk = '0; mbrk[0] = 1;
    rdr(ctl(0), v); chk("R13 brk status", v, 8'hC4);
    check_int("R13 brk irq");
    wrr(ctl(0), 8'h0F); wrr(ctl(0), 8'h00); mbrkie[0] = 0;
    check_int("R13 brk masked");
    rdr(ctl(0), v); chk("R13 brk sticky", v, 8'hC4);
    wrr(ctl(0), 8'h09); wrr(ctl(0), 8'h40); m_reset(0);
    rdr(ctl(0), v); chk("R13 brk reset", v, 8'h44);
    check_int("R13 end");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule